// File: doc/BRIEF.md
# Cascadable Presettable Four-Bit Counter

This block is a four-bit synchronous up-counter. It can be preset to any value, cleared to zero, and chained with other copies of itself. Two parameters pick the counting radix and the clear behaviour. The radix is either binary, which counts 0 to 15, or decimal, which counts 0 to 9. The clear is either taken on the clock edge or applied at once, without waiting for an edge.

The counter has two active-high enables. Both must be high for the counter to advance. Only the carry enable also qualifies the carry output, which is high while the counter sits at its last value.

To build a wider counter, connect the carry output of each stage to both enables of the next stage. Every stage shares the clock, so the chain stays fully synchronous.

Top module: `casc_counter`

## Requirements
- R1: When `clr_n` is low, the clear wins over every other input and the value becomes 0. With `CLR_MODE = CLR_ASYNC` the value is 0 as soon as `clr_n` falls, with no clock edge needed. With `CLR_MODE = CLR_SYNC` the value becomes 0 on the first rising edge of `clk` that samples `clr_n` low.
- R2: A rising edge with `clr_n` high and `preset_n` low loads `preset_val` into the value. The two enables have no effect on this load.
- R3: A rising edge with `clr_n`, `preset_n`, `count_en` and `carry_en` all high advances the value by one.
- R4: A rising edge with `clr_n` and `preset_n` high, but with `count_en` or `carry_en` low, leaves the value unchanged.
- R5: With `RADIX = CNT_BINARY`, an enabled count from 15 gives 0.
- R6: With `RADIX = CNT_DECADE`, an enabled count from 9 gives 0.
- R7: With `RADIX = CNT_DECADE`, a loaded value from 10 to 15 goes to 0 on the next enabled count.
- R8: `carry_out` is high exactly when `carry_en` is high and the value equals the terminal value. The terminal value is 15 in binary radix and 9 in decimal radix. `count_en` has no effect on `carry_out`.
- R9: While `carry_en` is low, `carry_out` is low, even when the value is at the terminal value.
- R10: Stage k+1 has both of its enables driven from the `carry_out` of stage k. A chain of three binary stages built this way counts as one 12-bit synchronous counter and wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge, except the asynchronous clear |
| clr_n | input | 1 | Active-low clear; highest priority |
| preset_n | input | 1 | Active-low synchronous parallel load |
| count_en | input | 1 | Count enable; does not affect the carry output |
| carry_en | input | 1 | Count enable that also qualifies `carry_out` |
| preset_val | input | WIDTH (4) | Value captured by a load |
| value | output | WIDTH (4) | Current count |
| carry_out | output | 1 | High while `carry_en` is high and the count is at its terminal value |

## Verification
The counter register is the only state in the block, so any wrong internal state appears on `value` at the sampling point right after the faulty edge. A wrong next-state choice is visible within one clock cycle. This includes a missed wrap, a load that lost to the enables, or an increment taken while an enable was low.

A faulty terminal-value comparison is seen at once on `carry_out`, because that output is combinational. In a chain, such a fault shows up in the upper stages on the very next edge.

An asynchronous clear that waits for an edge is caught between clock edges, before any edge arrives.

// File: rtl/cnt_pkg.sv
// Package: shared configuration types and helpers for the cascadable counter.
// Assumes WIDTH >= 4 whenever the decimal radix is selected.
package cnt_pkg;

    // Counting radix selector.
    typedef enum logic {
        CNT_BINARY = 1'b0,
        CNT_DECADE = 1'b1
    } radix_e;

    // Clear timing selector.
    typedef enum logic {
        CLR_SYNC  = 1'b0,
        CLR_ASYNC = 1'b1
    } clr_mode_e;

    // Last value before the counter wraps, for a given radix and width.
    function automatic int unsigned terminal_of(radix_e radix, int unsigned width);
        if (radix == CNT_DECADE) begin
            return 9;
        end
        return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/cnt_next_state.sv
// Next-state selector for one counter stage. A load wins over counting.
// A count needs both enables. In decimal radix, any value at or above the
// terminal value wraps to zero. The clear is handled in the register stage.
// Assumes the terminal value fits in WIDTH bits.
module cnt_next_state
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter radix_e      RADIX = CNT_BINARY
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] load_val,
    input  logic             load_n,
    input  logic             en_a,
    input  logic             en_b,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(terminal_of(RADIX, WIDTH));

    logic             step;
    logic [WIDTH-1:0] incr;

    // Wrap at or above the terminal value; otherwise add one.
    always_comb begin
        if (cur >= TERM) begin
            incr = '0;
        end else begin
            incr = cur + 1'b1;
        end
    end

    // The counter steps only when both enables are high.
    assign step = en_a & en_b;

    // Priority: load, then count, then hold.
    always_comb begin
        if (!load_n) begin
            nxt = load_val;
        end else if (step) begin
            nxt = incr;
        end else begin
            nxt = cur;
        end
    end
endmodule

// File: rtl/cnt_state_reg.sv
// Count register with an active-low clear. CLR_MODE selects whether the
// clear waits for the clock edge or takes effect at once.
// Assumes clr_n is synchronised upstream when the synchronous mode is used.
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter clr_mode_e   CLR_MODE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (CLR_MODE == CLR_ASYNC) begin : g_async
            // State update; the clear acts without a clock edge.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end else begin : g_sync
            // State update; the clear is sampled on the clock edge.
            always_ff @(posedge clk) begin
                if (!clr_n) begin
                    q <= '0;
                end else begin
                    q <= d;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cnt_carry.sv
// Carry decode. The output is high when the carry enable is high and the
// count equals the terminal value for the selected radix. It is
// combinational, so it follows the count within the same cycle.
module cnt_carry
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH = 4,
    parameter radix_e      RADIX = CNT_BINARY
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_carry,
    output logic             carry
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(terminal_of(RADIX, WIDTH));

    logic at_term;

    // Detect the terminal value.
    assign at_term = (cur == TERM);

    // The carry enable qualifies the carry output.
    assign carry = en_carry & at_term;
endmodule

// File: rtl/casc_counter.sv
// Top level of one cascadable counter stage. It is built from a next-state
// selector, a count register and a carry decode. To chain stages, drive
// both enables of a stage from the carry_out of the stage below it.
module casc_counter
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter radix_e      RADIX    = CNT_BINARY,
    parameter clr_mode_e   CLR_MODE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             preset_n,
    input  logic             count_en,
    input  logic             carry_en,
    input  logic [WIDTH-1:0] preset_val,
    output logic [WIDTH-1:0] value,
    output logic             carry_out
);
    logic [WIDTH-1:0] nxt_val;
    logic [WIDTH-1:0] cur_val;

    cnt_next_state #(.WIDTH(WIDTH), .RADIX(RADIX)) u_next (
        .cur      (cur_val),
        .load_val (preset_val),
        .load_n   (preset_n),
        .en_a     (count_en),
        .en_b     (carry_en),
        .nxt      (nxt_val)
    );

    cnt_state_reg #(.WIDTH(WIDTH), .CLR_MODE(CLR_MODE)) u_reg (
        .clk   (clk),
        .clr_n (clr_n),
        .d     (nxt_val),
        .q     (cur_val)
    );

    cnt_carry #(.WIDTH(WIDTH), .RADIX(RADIX)) u_carry (
        .cur      (cur_val),
        .en_carry (carry_en),
        .carry    (carry_out)
    );

    assign value = cur_val;
endmodule

// File: rtl/casc_counter_chk.sv
// Checker for casc_counter. It is bound to every instance and only watches
// the ports. It keeps one register that records the clear level seen at
// the last clock edge.
module casc_counter_chk
    import cnt_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter radix_e      RADIX    = CNT_BINARY,
    parameter clr_mode_e   CLR_MODE = CLR_SYNC
) (
    input logic             clk,
    input logic             clr_n,
    input logic             preset_n,
    input logic             count_en,
    input logic             carry_en,
    input logic [WIDTH-1:0] preset_val,
    input logic [WIDTH-1:0] value,
    input logic             carry_out
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(terminal_of(RADIX, WIDTH));

    logic clr_seen;

    // Remember the clear level sampled at the last rising edge.
    always_ff @(posedge clk) clr_seen <= clr_n;

    // R1
    always @(negedge clk) begin
        if (clr_seen === 1'b0) begin
            clear_zero_chk: assert (value == '0);
        end
    end

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !preset_n |=> value == $past(preset_val));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (preset_n && !(count_en && carry_en)) |=> $stable(value));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (preset_n && count_en && carry_en && $past(clr_n) && value < TERM)
        |=> value == $past(value) + 1'b1);

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (preset_n && count_en && carry_en && value >= TERM) |=> value == '0);

    // R9
    carry_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !carry_en |-> !carry_out);

    // R8
    carry_term_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> value == TERM);
endmodule

bind casc_counter casc_counter_chk #(
    .WIDTH    (WIDTH),
    .RADIX    (RADIX),
    .CLR_MODE (CLR_MODE)
) u_chk (
    .clk        (clk),
    .clr_n      (clr_n),
    .preset_n   (preset_n),
    .count_en   (count_en),
    .carry_en   (carry_en),
    .preset_val (preset_val),
    .value      (value),
    .carry_out  (carry_out)
);

// File: tb/test_casc_counter.sv
module test_casc_counter;
    import cnt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Stimulus shared by the four single-stage variants.
    logic       clr_n = 1'b0;
    logic       ld    = 1'b1;
    logic       p     = 1'b0;
    logic       t     = 1'b0;
    logic [3:0] d     = '0;

    // Stimulus for the three-stage chain.
    logic        ld_c = 1'b1;
    logic        en_c = 1'b0;
    logic [11:0] d_c  = '0;

    logic [3:0] val_q [NV];
    logic       rc_q  [NV];
    logic [3:0] mdl   [NV];

    logic [3:0] cv0, cv1, cv2;
    logic       cr0, cr1, cr2;
    logic [11:0] c_mdl;

    int checks   = 0;
    int failures = 0;
    string cur_req = "R1";

    // Variant index: 0 binary/sync, 1 binary/async, 2 decimal/sync, 3 decimal/async.
    casc_counter #(.RADIX(CNT_BINARY), .CLR_MODE(CLR_SYNC)) i_casc_counter (
        .clk(clk), .clr_n(clr_n), .preset_n(ld), .count_en(p), .carry_en(t),
        .preset_val(d), .value(val_q[0]), .carry_out(rc_q[0]));
    casc_counter #(.RADIX(CNT_BINARY), .CLR_MODE(CLR_ASYNC)) i_casc_counter_ba (
        .clk(clk), .clr_n(clr_n), .preset_n(ld), .count_en(p), .carry_en(t),
        .preset_val(d), .value(val_q[1]), .carry_out(rc_q[1]));
    casc_counter #(.RADIX(CNT_DECADE), .CLR_MODE(CLR_SYNC)) i_casc_counter_ds (
        .clk(clk), .clr_n(clr_n), .preset_n(ld), .count_en(p), .carry_en(t),
        .preset_val(d), .value(val_q[2]), .carry_out(rc_q[2]));
    casc_counter #(.RADIX(CNT_DECADE), .CLR_MODE(CLR_ASYNC)) i_casc_counter_da (
        .clk(clk), .clr_n(clr_n), .preset_n(ld), .count_en(p), .carry_en(t),
        .preset_val(d), .value(val_q[3]), .carry_out(rc_q[3]));

    // R10: three chained binary stages.
    casc_counter i_casc_counter_s0 (
        .clk(clk), .clr_n(clr_n), .preset_n(ld_c), .count_en(en_c), .carry_en(en_c),
        .preset_val(d_c[3:0]), .value(cv0), .carry_out(cr0));
    casc_counter i_casc_counter_s1 (
        .clk(clk), .clr_n(clr_n), .preset_n(ld_c), .count_en(cr0), .carry_en(cr0),
        .preset_val(d_c[7:4]), .value(cv1), .carry_out(cr1));
    casc_counter i_casc_counter_s2 (
        .clk(clk), .clr_n(clr_n), .preset_n(ld_c), .count_en(cr1), .carry_en(cr1),
        .preset_val(d_c[11:8]), .value(cv2), .carry_out(cr2));

    function automatic bit is_dec(int i);
        return i >= 2;
    endfunction

    function automatic int term_of(int i);
        return is_dec(i) ? 9 : 15;
    endfunction

    // Requirement exercised by the coming edge for variant i.
    function automatic string req_for(int i, int prev);
        if (!clr_n) return "R1";
        if (!ld) return "R2";
        if (p && t) begin
            if (is_dec(i) && prev == 9) return "R6";
            if (is_dec(i) && prev > 9) return "R7";
            if (!is_dec(i) && prev == 15) return "R5";
            return "R3";
        end
        return "R4";
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: update the models at the edge, then compare at the next falling edge.
    task automatic tick();
        string reqs [NV];
        for (int i = 0; i < NV; i++) begin
            reqs[i] = req_for(i, int'(mdl[i]));
        end
        @(posedge clk);
        for (int i = 0; i < NV; i++) begin
            if (!clr_n) mdl[i] = 4'd0;
            else if (!ld) mdl[i] = d;
            else if (p && t) mdl[i] = (int'(mdl[i]) >= term_of(i)) ? 4'd0 : mdl[i] + 4'd1;
        end
        if (!clr_n) c_mdl = '0;
        else if (!ld_c) c_mdl = d_c;
        else if (en_c) c_mdl = c_mdl + 12'd1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            check(reqs[i], int'(val_q[i]), int'(mdl[i]));
            if (t) check("R8", int'(rc_q[i]), int'(int'(mdl[i]) == term_of(i)));
            else   check("R9", int'(rc_q[i]), 0);
        end
        check("R10", int'({cv2, cv1, cv0}), int'(c_mdl));
        check("R10", int'(cr2), int'(en_c && c_mdl == 12'hFFF));
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NV; i++) mdl[i] = '0;
        c_mdl = '0;
        // R1: reset state with the clear held low.
        clr_n = 1'b0;
        cur_req = "R1";
        repeat (3) tick();
        clr_n = 1'b1;

        // Near-exhaustive sweep: every start value and every control combination.
        for (int s = 0; s < 16; s++) begin
            for (int c = 0; c < 8; c++) begin
                ld = 1'b0; d = 4'(s); p = 1'b0; t = 1'b0;
                tick();                              // R2 load, enables low
                ld = c[2]; p = c[1]; t = c[0]; d = ~4'(s);
                tick();                              // R2/R3/R4/R5/R6/R7/R8/R9
            end
        end

        // R3 R5 R6: free running from zero through several wraps.
        ld = 1'b0; d = 4'd0; tick();
        ld = 1'b1; p = 1'b1; t = 1'b1;
        repeat (40) tick();

        // R8: count_en low at a terminal value keeps the carry tied to carry_en.
        ld = 1'b0; d = 4'd9; p = 1'b0; t = 1'b1; tick();
        ld = 1'b1; repeat (2) tick();

        // R1: clear during a load wins.
        clr_n = 1'b0; ld = 1'b0; d = 4'd5; ld_c = 1'b0; d_c = 12'h123;
        tick();
        clr_n = 1'b1; ld_c = 1'b1;

        // R1: an asynchronous clear acts between edges; a synchronous one waits.
        ld = 1'b0; d = 4'd7; p = 1'b0; t = 1'b0; tick();
        ld = 1'b1;
        #1 clr_n = 1'b0;
        #1;
        check("R1", int'(val_q[1]), 0);
        check("R1", int'(val_q[3]), 0);
        check("R1", int'(val_q[0]), 7);
        check("R1", int'(val_q[2]), 7);
        mdl[1] = '0; mdl[3] = '0;
        tick();
        clr_n = 1'b1;

        // R10: chain rollover across all twelve bits.
        ld_c = 1'b0; d_c = 12'hFF0; tick();
        ld_c = 1'b1; en_c = 1'b1;
        repeat (40) tick();
        ld_c = 1'b0; d_c = 12'h0F8; en_c = 1'b0; tick();
        ld_c = 1'b1; en_c = 1'b1;
        repeat (20) tick();
        en_c = 1'b0; repeat (3) tick();              // R10 hold with the chain idle

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
        $finish;
    end
endmodule